// File: doc/BRIEF.md
# Codec serial port frame handler

This block is the slave side of a full-duplex synchronous serial link between a host processor and a codec front end. A host supplies the serial clock and a frame sync, then exchanges 16-bit words with the block. Inbound words are either settings for a small bank of 8-bit control registers or samples for the DAC. Outbound words carry ADC samples or the contents of a register that the host asked to read.

A single 16-bit shift register carries traffic in both directions. Whenever the sample-event strobe fires, the register is overwritten with the next outbound word. That word is the newest ADC sample, or a pending register read-back. The host then clocks it out while clocking its own word in. The low two bits of register 0 pick one of three routings for inbound words. All words can be control words, all words can be DAC samples, or the top bit of each word can choose between the two. In that last case the sample resolution drops to 15 bits.

The block runs on a fast system clock and oversamples the serial clock to find its edges. A received word takes effect only on the falling serial clock edge that follows its sixteenth bit.

Top module: `codec_sport`

## Requirements
- R1: After reset every control register reads 0x00, the DAC output is 0x0000, the serial output is 0, and the block is in control routing.
- R2: A rising serial clock edge that sees frame sync high arms a transfer. The next 16 rising edges each shift one serial input bit in, MSB first. The received word takes effect only after the falling edge that follows the 16th bit, and not before it.
- R3: While register 0 bit 0 is 0, whatever bit 1 holds, every word is a control word and its bit 15 is ignored. A control word has bit 14 = 0 for a write, bits 13:11 as the register address and bits 7:0 as the data byte. A write stores the byte in the addressed register.
- R4: There are six registers, at addresses 0 to 5. A write to address 6 or 7 changes no register, and a read of address 6 or 7 returns the data byte 0x00.
- R5: A control word with bit 14 = 1 requests a read. At the next sample event the shift register is loaded with {1, 1, address[2:0], 000, data[7:0]} in place of ADC data. This applies in control routing and in split routing alike.
- R6: In control and data routing, a sample event with no read pending loads the full 16-bit ADC input. The serial output always shows the shift register MSB, so the next transfer sends that word MSB first.
- R7: With register 0 bits 1:0 = 01 (data routing), every received word is copied unchanged to the DAC output and no control register changes.
- R8: With register 0 bits 1:0 = 11 (split routing), a word with bit 15 = 0 sets the DAC output to {word[14:0], 0}. A word with bit 15 = 1 is a control word as in R3, R4 and R5.
- R9: In split routing, a sample event with no read pending loads {0, adc[15:1]}.
- R10: A sample event overwrites the shift register even in the middle of a transfer. The remaining bits keep shifting in, and the mixed word that results is the one that takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| fsync | input | 1 | Frame sync, high for one serial clock before the first bit |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host (shift register MSB) |
| sample_evt | input | 1 | One-cycle output sample event strobe |
| adc_in | input | 16 | Newest ADC sample word |
| dac_out | output | 16 | DAC data register |
| ctrl_regs | output | 48 | Control registers, register n at bits 8n+7:8n |

## Verification
A write sweep covers all eight addresses with bit 15 toggling. This separates real writes from the ignored addresses 6 and 7, and shows that bit 15 has no effect in control routing. A read sweep over the same addresses checks the read-back format and the zero returned for unimplemented addresses. In split and data routing, DAC words and ADC words are swept together with arithmetic patterns. These sweeps separate the 15-bit left-justified path from the full 16-bit path, and they include words that look like control writes, to show that data routing never touches the registers. Sample events injected after 1, 5 and 12 bits of a transfer show how the shared register mixes old and new bits. A sample of the DAC output just before the final falling edge shows that a word does not take effect early.

// File: rtl/codec_sport_pkg.sv
package codec_sport_pkg;

    localparam int WORD_W   = 16;
    localparam int REG_W    = 8;
    localparam int ADDR_W   = 3;
    localparam int NUM_REGS = 6;
    localparam int RSVD_W   = WORD_W - 2 - ADDR_W - REG_W;

    typedef enum logic [1:0] {
        ROUTE_CTRL  = 2'd0,
        ROUTE_DATA  = 2'd1,
        ROUTE_SPLIT = 2'd2
    } route_e;

    typedef struct packed {
        logic              flag;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [RSVD_W-1:0] rsvd;
        logic [REG_W-1:0]  data;
    } ctl_word_t;

    function automatic route_e decode_route(input logic [1:0] sel);
        if (!sel[0])
            return ROUTE_CTRL;
        else if (sel[1])
            return ROUTE_SPLIT;
        else
            return ROUTE_DATA;
    endfunction

    function automatic logic [WORD_W-1:0] readback_word(input logic [ADDR_W-1:0] a,
                                                        input logic [REG_W-1:0]  d);
        ctl_word_t w;
        w.flag = 1'b1;
        w.rd   = 1'b1;
        w.addr = a;
        w.rsvd = '0;
        w.data = d;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] split_adc(input logic [WORD_W-1:0] s);
        return {1'b0, s[WORD_W-1:1]};
    endfunction

endpackage

// File: rtl/sport_edge_det.sv
module sport_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    output logic rise_o,
    output logic fall_o
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst)
            sclk_q <= 1'b0;
        else
            sclk_q <= sclk_i;
    end

    assign rise_o = sclk_i & ~sclk_q;
    assign fall_o = ~sclk_i & sclk_q;
endmodule

// File: rtl/sport_shifter.sv
module sport_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rise_i,
    input  logic         fall_i,
    input  logic         fsync_i,
    input  logic         sdi_i,
    input  logic         load_i,
    input  logic [W-1:0] load_word_i,
    output logic         sdo_o,
    output logic         commit_o,
    output logic [W-1:0] rx_word_o
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  sh;
    logic          active;
    logic [CW-1:0] cnt;
    logic          done_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh        <= '0;
            active    <= 1'b0;
            cnt       <= '0;
            done_pend <= 1'b0;
            commit_o  <= 1'b0;
        end else begin
            commit_o <= 1'b0;
            if (load_i)
                sh <= load_word_i;
            else if (rise_i && active)
                sh <= {sh[W-2:0], sdi_i};

            if (rise_i) begin
                if (active) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(W-1)) begin
                        active    <= 1'b0;
                        done_pend <= 1'b1;
                    end
                end else if (fsync_i) begin
                    active <= 1'b1;
                    cnt    <= '0;
                end
            end

            if (fall_i && done_pend) begin
                commit_o  <= 1'b1;
                done_pend <= 1'b0;
            end
        end
    end

    assign sdo_o     = sh[W-1];
    assign rx_word_o = sh;
endmodule

// File: rtl/sport_reg_bank.sv
module sport_reg_bank #(
    parameter int NUM = 6,
    parameter int RW  = 8,
    parameter int AW  = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en_i,
    input  logic [AW-1:0]   wr_addr_i,
    input  logic [RW-1:0]   wr_data_i,
    input  logic [AW-1:0]   rd_addr_i,
    output logic [RW-1:0]   rd_data_o,
    output logic [NUM*RW-1:0] regs_o
);
    logic [RW-1:0] regs [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (wr_en_i && wr_addr_i == AW'(g))
                regs[g] <= wr_data_i;
        end
        assign regs_o[g*RW +: RW] = regs[g];
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NUM; i++) begin
            if (rd_addr_i == AW'(i))
                rd_data_o = regs[i];
        end
    end
endmodule

// File: rtl/sport_router.sv
module sport_router
    import codec_sport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit_i,
    input  logic [WORD_W-1:0] rx_word_i,
    input  route_e            route_i,
    input  logic [REG_W-1:0]  rd_data_i,
    input  logic              sample_evt_i,
    input  logic [WORD_W-1:0] adc_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [REG_W-1:0]  wr_data_o,
    output logic [WORD_W-1:0] dac_o,
    output logic [WORD_W-1:0] load_word_o,
    output logic              rd_pend_o
);
    logic              is_ctl;
    logic              is_rd;
    logic [WORD_W-1:0] rd_word;

    assign addr_o    = rx_word_i[WORD_W-3 -: ADDR_W];
    assign wr_data_o = rx_word_i[REG_W-1:0];
    assign is_rd     = rx_word_i[WORD_W-2];

    always_comb begin
        is_ctl = 1'b0;
        case (route_i)
            ROUTE_CTRL:  is_ctl = 1'b1;
            ROUTE_SPLIT: is_ctl = rx_word_i[WORD_W-1];
            default:     is_ctl = 1'b0;
        endcase
    end

    assign wr_en_o = commit_i && is_ctl && !is_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_o     <= '0;
            rd_pend_o <= 1'b0;
            rd_word   <= '0;
        end else begin
            if (sample_evt_i)
                rd_pend_o <= 1'b0;
            if (commit_i) begin
                if (is_ctl) begin
                    if (is_rd) begin
                        rd_pend_o <= 1'b1;
                        rd_word   <= readback_word(addr_o, rd_data_i);
                    end
                end else if (route_i == ROUTE_SPLIT) begin
                    dac_o <= {rx_word_i[WORD_W-2:0], 1'b0};
                end else begin
                    dac_o <= rx_word_i;
                end
            end
        end
    end

    always_comb begin
        if (rd_pend_o)
            load_word_o = rd_word;
        else if (route_i == ROUTE_SPLIT)
            load_word_o = split_adc(adc_i);
        else
            load_word_o = adc_i;
    end
endmodule

// File: rtl/codec_sport.sv
module codec_sport
    import codec_sport_pkg::*;
#(
    parameter int NUM_REGS_P = NUM_REGS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sclk,
    input  logic                      fsync,
    input  logic                      sdi,
    output logic                      sdo,
    input  logic                      sample_evt,
    input  logic [WORD_W-1:0]         adc_in,
    output logic [WORD_W-1:0]         dac_out,
    output logic [NUM_REGS_P*REG_W-1:0] ctrl_regs
);
    logic              sclk_rise;
    logic              sclk_fall;
    logic              frame_commit;
    logic [WORD_W-1:0] rx_word;
    logic [WORD_W-1:0] load_word;
    logic              read_pending;
    logic              wr_en;
    logic [ADDR_W-1:0] reg_addr;
    logic [REG_W-1:0]  wr_data;
    logic [REG_W-1:0]  rd_data;
    route_e            route;

    assign route = decode_route(ctrl_regs[1:0]);

    sport_edge_det u_edge (
        .clk    (clk),
        .rst    (rst),
        .sclk_i (sclk),
        .rise_o (sclk_rise),
        .fall_o (sclk_fall)
    );

    sport_shifter #(.W(WORD_W)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .rise_i      (sclk_rise),
        .fall_i      (sclk_fall),
        .fsync_i     (fsync),
        .sdi_i       (sdi),
        .load_i      (sample_evt),
        .load_word_i (load_word),
        .sdo_o       (sdo),
        .commit_o    (frame_commit),
        .rx_word_o   (rx_word)
    );

    sport_router u_route (
        .clk          (clk),
        .rst          (rst),
        .commit_i     (frame_commit),
        .rx_word_i    (rx_word),
        .route_i      (route),
        .rd_data_i    (rd_data),
        .sample_evt_i (sample_evt),
        .adc_i        (adc_in),
        .wr_en_o      (wr_en),
        .addr_o       (reg_addr),
        .wr_data_o    (wr_data),
        .dac_o        (dac_out),
        .load_word_o  (load_word),
        .rd_pend_o    (read_pending)
    );

    sport_reg_bank #(.NUM(NUM_REGS_P), .RW(REG_W), .AW(ADDR_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en),
        .wr_addr_i (reg_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (reg_addr),
        .rd_data_o (rd_data),
        .regs_o    (ctrl_regs)
    );
endmodule

// File: rtl/codec_sport_chk.sv
module codec_sport_chk #(
    parameter int WW = 16,
    parameter int RB = 48
) (
    input logic          clk,
    input logic          rst,
    input logic          sclk,
    input logic          sample_evt,
    input logic          adc_msb,
    input logic          sdo,
    input logic [WW-1:0] dac_out,
    input logic [RB-1:0] ctrl_regs,
    input logic          commit,
    input logic          rd_pend
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dac_out == '0 && ctrl_regs == '0 && !sdo));

    // R2
    commit_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        commit |-> !sclk);

    // R7
    dac_after_commit_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(dac_out) |-> $past(commit));

    // R3
    regs_after_commit_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_regs) |-> $past(commit));

    // R6
    adc_load_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(sample_evt) && !$past(rst) && !$past(rd_pend) && $past(ctrl_regs[1:0]) != 2'b11)
        |-> (sdo == $past(adc_msb)));

    // R9
    split_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(sample_evt) && !$past(rst) && !$past(rd_pend) && $past(ctrl_regs[1:0]) == 2'b11)
        |-> !sdo);

    // R5
    readback_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(sample_evt) && !$past(rst) && $past(rd_pend)) |-> sdo);
endmodule

bind codec_sport codec_sport_chk #(.WW(codec_sport_pkg::WORD_W),
                                   .RB(NUM_REGS_P*codec_sport_pkg::REG_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sclk       (sclk),
    .sample_evt (sample_evt),
    .adc_msb    (adc_in[codec_sport_pkg::WORD_W-1]),
    .sdo        (sdo),
    .dac_out    (dac_out),
    .ctrl_regs  (ctrl_regs),
    .commit     (frame_commit),
    .rd_pend    (read_pending)
);

// File: tb/codec_sport_bench.sv
module codec_sport_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0;
    logic        fsync = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo;
    logic        sample_evt = 1'b0;
    logic [15:0] adc_in = '0;
    logic [15:0] dac_out;
    logic [47:0] ctrl_regs;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0]  mreg [6];
    logic [15:0] dac_pre;
    logic [15:0] rx;
    logic [15:0] exp_dac;

    always #2 clk = ~clk;

    codec_sport u_codec_sport (
        .clk        (clk),
        .rst        (rst),
        .sclk       (sclk),
        .fsync      (fsync),
        .sdi        (sdi),
        .sdo        (sdo),
        .sample_evt (sample_evt),
        .adc_in     (adc_in),
        .dac_out    (dac_out),
        .ctrl_regs  (ctrl_regs)
    );

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [47:0] model_flat();
        logic [47:0] f;
        for (int i = 0; i < 6; i++) f[i*8 +: 8] = mreg[i];
        return f;
    endfunction

    function automatic logic [15:0] ctl_word(input logic flag, input logic rd,
                                             input logic [2:0] a, input logic [7:0] d);
        return {flag, rd, a, 3'b000, d};
    endfunction

    task automatic pulse_sample(input logic [15:0] w);
        adc_in = w;
        sample_evt = 1'b1;
        @(negedge clk);
        sample_evt = 1'b0;
        @(negedge clk);
    endtask

    task automatic xfer(input logic [15:0] tx, input int mid_k, input logic [15:0] mid_w,
                        output logic [15:0] rxo);
        fsync = 1'b1;
        sclk = 1'b1; wait_n(4);
        sclk = 1'b0; wait_n(4);
        fsync = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            if (mid_k > 0 && (15 - i) == mid_k) pulse_sample(mid_w);
            sdi = tx[i];
            rxo[i] = sdo;
            sclk = 1'b1; wait_n(4);
            if (i == 0) dac_pre = dac_out;
            sclk = 1'b0; wait_n(4);
        end
        wait_n(4);
    endtask

    task automatic ctl_write(input logic flag, input logic [2:0] a, input logic [7:0] d);
        logic [15:0] r;
        xfer(ctl_word(flag, 1'b0, a, d), 0, 16'h0, r);
        if (a < 3'd6) mreg[a] = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 6; i++) mreg[i] = 8'h00;
        wait_n(5);
        rst = 1'b0;
        wait_n(2);

        // R1 reset state
        check("R1 dac", {32'h0, dac_out}, 48'h0);
        check("R1 regs", ctrl_regs, 48'h0);
        check("R1 sdo", {47'h0, sdo}, 48'h0);

        // R3 R4 write sweep, bit 15 toggled and ignored in control routing
        for (int a = 0; a < 8; a++) begin
            logic [7:0] v;
            v = 8'(a * 8'h11 + 8'h0C);
            ctl_write(a[0], 3'(a), v);
            check(a < 6 ? "R3 write" : "R4 write ignored", ctrl_regs, model_flat());
        end

        // R3 bit1 alone keeps control routing
        ctl_write(1'b0, 3'd0, 8'h02);
        ctl_write(1'b1, 3'd2, 8'h55);
        check("R3 ctrl with bit1", ctrl_regs, model_flat());
        check("R3 dac untouched", {32'h0, dac_out}, 48'h0);

        // R5 R4 read sweep
        for (int a = 0; a < 8; a++) begin
            logic [15:0] r;
            logic [7:0]  e;
            e = (a < 6) ? mreg[a] : 8'h00;
            xfer(ctl_word(1'b0, 1'b1, 3'(a), 8'h00), 0, 16'h0, r);
            pulse_sample(16'hFFFF);
            xfer(ctl_word(1'b0, 1'b0, 3'd7, 8'hAA), 0, 16'h0, rx);
            check(a < 6 ? "R5 readback" : "R4 read zero", {32'h0, rx},
                  {32'h0, 2'b11, 3'(a), 3'b000, e});
        end

        // R6 ADC word in control routing
        pulse_sample(16'hA5C3);
        check("R6 sdo msb after load", {47'h0, sdo}, 48'h1);
        xfer(ctl_word(1'b0, 1'b0, 3'd6, 8'h00), 0, 16'h0, rx);
        check("R6 adc out ctrl", {32'h0, rx}, 48'hA5C3);

        // enter split routing
        ctl_write(1'b0, 3'd0, 8'h03);
        check("R8 reg0 split", ctrl_regs, model_flat());

        // R8 R9 sweep
        for (int k = 0; k < 64; k++) begin
            logic [14:0] p;
            logic [15:0] s;
            p = 15'(k * 16'h02F1 + 16'h1234);
            s = 16'(k * 16'h9E37 + 16'h0101);
            pulse_sample(s);
            xfer({1'b0, p}, 0, 16'h0, rx);
            check("R8 split dac", {32'h0, dac_out}, {32'h0, p, 1'b0});
            check("R9 split adc", {32'h0, rx}, {32'h0, 1'b0, s[15:1]});
        end
        check("R8 regs kept", ctrl_regs, model_flat());

        // R8 control word in split routing, R5 read in split routing
        ctl_write(1'b1, 3'd4, 8'h3C);
        check("R8 split write", ctrl_regs, model_flat());
        xfer(ctl_word(1'b1, 1'b1, 3'd4, 8'h00), 0, 16'h0, rx);
        pulse_sample(16'h1357);
        xfer(16'h2222, 0, 16'h0, rx);
        check("R5 split readback", {32'h0, rx}, {32'h0, 2'b11, 3'd4, 3'b000, 8'h3C});
        check("R8 split dac after read", {32'h0, dac_out}, 48'h4444);

        // R2 commit waits for the falling edge
        xfer(16'h0F0F, 0, 16'h0, rx);
        check("R2 before fall", {32'h0, dac_pre}, 48'h4444);
        check("R2 after fall", {32'h0, dac_out}, 48'h1E1E);

        // enter data routing
        ctl_write(1'b1, 3'd0, 8'h01);
        check("R7 reg0 data", ctrl_regs, model_flat());

        // R6 R7 data sweep, includes words shaped like control writes
        for (int k = 0; k < 32; k++) begin
            logic [15:0] w;
            logic [15:0] s;
            w = (k % 4 == 0) ? ctl_word(1'b1, 1'b0, 3'(k % 6), 8'(k)) : 16'(k * 16'h3B5D + 16'h8001);
            s = 16'(k * 16'h7F4B + 16'h0003);
            pulse_sample(s);
            xfer(w, 0, 16'h0, rx);
            check("R7 data dac", {32'h0, dac_out}, {32'h0, w});
            check("R6 data adc", {32'h0, rx}, {32'h0, s});
        end
        check("R7 regs untouched", ctrl_regs, model_flat());

        // R10 sample event inside a transfer
        for (int j = 0; j < 3; j++) begin
            int k;
            logic [15:0] tx;
            logic [15:0] mw;
            logic [15:0] m;
            k  = (j == 0) ? 1 : (j == 1) ? 5 : 12;
            tx = 16'hC3A6 ^ 16'(j * 16'h1111);
            mw = 16'h5A96 + 16'(j);
            m  = 16'((32'h1 << (16 - k)) - 1);
            exp_dac = 16'(mw << (16 - k)) | (tx & m);
            xfer(tx, k, mw, rx);
            check("R10 mid overwrite", {32'h0, dac_out}, {32'h0, exp_dac});
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule